// File: doc/BRIEF.md
# Narrow-Write Merging Register Bridge

This bridge connects a host that issues 8-bit and 16-bit register writes to a peripheral register file that only takes aligned 32-bit accesses. For most addresses it reads the aligned word, replaces the addressed lane, and writes the whole word back. The downstream device can drop a second write to the same 32-bit register when it follows the first too closely. To avoid this, the bridge never sends the two halves of the block word, or the two halves of the command word, as separate back-to-back writes.

Half-word writes to block size (0x04) and block count (0x06) are collected in a block shadow word. A half-word write to transfer mode (0x0C) is kept in a command shadow word. Nothing goes downstream until the host writes the command half-word (0x0E). That write releases the pending block word, if there is one, and then a single word made of transfer mode and command.

The host side is a valid/ready request. A request is taken on a cycle where `h_valid` and `h_ready` are both high. While a request is pending the host must hold `h_addr`, `h_wdata`, `h_half` and `h_we` stable. `h_ready` stays low until the downstream read-modify-write or flush sequence has finished. The downstream side has a single outstanding access. `d_req` and its qualifiers stay stable until a one-cycle `d_rsp` arrives, and `d_rdata` is valid in that cycle.

Top module: `nw_merge_bridge`

## Requirements
- R1: A byte write (`h_half`=0) at address A reads the word at A with bits [1:0] cleared. It replaces bits [8*A[1:0]+7 : 8*A[1:0]] with `h_wdata[7:0]` and writes the word back to the same aligned address. This applies to every address, including the block word.
- R2: A half-word write to an address outside 0x04, 0x06, 0x0C and 0x0E reads the aligned word. It replaces bits [31:16] when A[1]=1, or bits [15:0] otherwise, with `h_wdata` and writes the word back.
- R3: When no block shadow is pending, a half-word write to 0x04 or 0x06 makes exactly one downstream read of word 0x04. It merges the value into that word, keeps the result as the pending block shadow, and writes nothing downstream.
- R4: When a block shadow is pending, a further half-word write to 0x04 or 0x06 merges into the shadow. It makes no downstream access, and `h_ready` is high again in the cycle after acceptance.
- R5: A half-word write to 0x0C makes one downstream read of word 0x0C. It merges the value into bits [15:0], keeps the result as the command shadow, and writes nothing downstream.
- R6: A half-word write to 0x0E while a block shadow is pending produces two downstream writes in this order: the block shadow to 0x04, then the command shadow with bits [31:16] replaced by `h_wdata` to 0x0C. No read is made.
- R7: A half-word write to 0x0E with no pending block shadow produces only the 0x0C write, built from the command shadow as in R6. Each 0x0E write clears both pending flags, and the command shadow word itself keeps its value.
- R8: A half-word write with A[0]=1 makes no downstream access and changes no state. `h_err` is high for exactly the one cycle after its acceptance.
- R9: After reset `h_ready`=1, `d_req`=0 and `h_err`=0, and no block or command shadow is pending.
- R10: While `d_req` is high and `d_rsp` is low, `d_req`, `d_we` and `d_addr` hold their values, and `h_ready` is low.
- R11: A request with `h_we`=0 is accepted in one cycle and causes no downstream access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | HALF_W | Write data (byte in [7:0]) |
| h_half | input | 1 | 1 = half-word, 0 = byte |
| h_we | input | 1 | 1 = write, 0 = read (ignored) |
| h_err | output | 1 | Misaligned half-word write seen |
| d_req | output | 1 | Downstream access request |
| d_we | output | 1 | Downstream write (1) or read (0) |
| d_addr | output | ADDR_W | Downstream aligned word address |
| d_wdata | output | WORD_W | Downstream write data |
| d_rdata | input | WORD_W | Downstream read data |
| d_rsp | input | 1 | Downstream response, one cycle |

## Verification
The bench builds the bridge with its default parameters: an 8-bit address, 32-bit words, and the four register offsets 0x04, 0x06, 0x0C and 0x0E. The downstream stub answers every access two cycles after the request. With these values every byte lane and both half-word lanes can be reached, as well as both flush shapes, one write and two. The stub's latency also keeps `h_ready` low for several cycles, which exercises back-pressure. A byte write that lands in the block word while a block shadow is pending shows that the two paths stay separate: the later flush overwrites the byte.

// File: rtl/nwmb_pkg.sv
package nwmb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FLB,
    ST_FLC
  } seq_st_t;

  typedef enum logic [1:0] {
    K_PLAIN,
    K_BLK,
    K_XFER,
    K_CMD
  } wr_kind_t;

endpackage

// File: rtl/nwmb_lane_merge.sv
module nwmb_lane_merge #(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic [WORD_W-1:0] base,
  input  logic [HALF_W-1:0] val,
  input  logic              is_half,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] merged
);
  localparam int SH_W   = $clog2(WORD_W);
  localparam int BYTE_W = 8;

  logic [SH_W-1:0]   sh;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] ins;

  always_comb begin
    if (is_half) begin
      sh   = off[OFF_W-1] ? SH_W'(HALF_W) : '0;
      mask = WORD_W'({HALF_W{1'b1}}) << sh;
      ins  = WORD_W'(val) << sh;
    end else begin
      sh   = SH_W'(off) << 3;
      mask = WORD_W'({BYTE_W{1'b1}}) << sh;
      ins  = WORD_W'(val[BYTE_W-1:0]) << sh;
    end
    merged = (base & ~mask) | (ins & mask);
  end
endmodule

// File: rtl/nwmb_shadow.sv
module nwmb_shadow #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_ld,
  input  logic              blk_clr,
  input  logic              cmd_ld,
  input  logic              cmd_clr,
  input  logic [WORD_W-1:0] ld_word,
  output logic [WORD_W-1:0] blk_word,
  output logic              blk_vld,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_word <= '0;
      blk_vld  <= 1'b0;
      cmd_word <= '0;
      cmd_vld  <= 1'b0;
    end else begin
      if (blk_ld) begin
        blk_word <= ld_word;
        blk_vld  <= 1'b1;
      end else if (blk_clr) begin
        blk_vld  <= 1'b0;
      end
      if (cmd_ld) begin
        cmd_word <= ld_word;
        cmd_vld  <= 1'b1;
      end else if (cmd_clr) begin
        cmd_vld  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nw_merge_bridge.sv
module nw_merge_bridge
  import nwmb_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          WORD_W    = 32,
  parameter int          HALF_W    = 16,
  parameter int unsigned BLK_ADDR  = 'h04,
  parameter int unsigned XFER_ADDR = 'h0C,
  parameter int unsigned CMD_ADDR  = 'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [HALF_W-1:0] h_wdata,
  input  logic              h_half,
  input  logic              h_we,
  output logic              h_err,
  output logic              d_req,
  output logic              d_we,
  output logic [ADDR_W-1:0] d_addr,
  output logic [WORD_W-1:0] d_wdata,
  input  logic [WORD_W-1:0] d_rdata,
  input  logic              d_rsp
);
  localparam int OFF_W = $clog2(WORD_W / 8);
  localparam logic [ADDR_W-1:0] AL_MASK  = ~ADDR_W'((1 << OFF_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_WORD = ADDR_W'(BLK_ADDR) & AL_MASK;
  localparam logic [ADDR_W-1:0] CMD_WORD = ADDR_W'(CMD_ADDR) & AL_MASK;
  localparam logic [ADDR_W-1:0] XFER_A   = ADDR_W'(XFER_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A    = ADDR_W'(CMD_ADDR);

  seq_st_t           st;
  wr_kind_t          in_kind, r_kind;
  logic [ADDR_W-1:0] r_addr;
  logic [HALF_W-1:0] r_data;
  logic              r_half;
  logic [WORD_W-1:0] wr_word;

  logic              acc, misalign, take;
  logic [ADDR_W-1:0] h_al, r_al;

  logic [WORD_W-1:0] m_base, m_out;
  logic [HALF_W-1:0] m_val;
  logic              m_half;
  logic [OFF_W-1:0]  m_off;

  logic              blk_ld, blk_clr, cmd_ld, cmd_clr;
  logic [WORD_W-1:0] sh_blk, sh_cmd;
  logic              blk_vld, cmd_vld;

  assign h_ready  = (st == ST_IDLE);
  assign acc      = h_valid & h_ready;
  assign misalign = h_half & h_addr[0];
  assign take     = acc & h_we & ~misalign;
  assign h_al     = h_addr & AL_MASK;
  assign r_al     = r_addr & AL_MASK;

  // classify the incoming write by address
  always_comb begin
    in_kind = K_PLAIN;
    if (h_half) begin
      if (h_al == BLK_WORD)    in_kind = K_BLK;
      else if (h_addr == XFER_A) in_kind = K_XFER;
      else if (h_addr == CMD_A)  in_kind = K_CMD;
    end
  end

  // one lane merger shared by every path; the base word depends on phase
  always_comb begin
    if (st == ST_IDLE) begin
      m_base = sh_blk;
      m_val  = h_wdata;
      m_half = h_half;
      m_off  = h_addr[OFF_W-1:0];
    end else begin
      m_base = (st == ST_FLC) ? sh_cmd : d_rdata;
      m_val  = r_data;
      m_half = r_half;
      m_off  = r_addr[OFF_W-1:0];
    end
  end

  nwmb_lane_merge #(.WORD_W(WORD_W), .HALF_W(HALF_W), .OFF_W(OFF_W)) u_merge (
    .base(m_base), .val(m_val), .is_half(m_half), .off(m_off), .merged(m_out)
  );

  assign blk_ld  = (take && in_kind == K_BLK && blk_vld) ||
                   (st == ST_RD && d_rsp && r_kind == K_BLK);
  assign cmd_ld  = (st == ST_RD && d_rsp && r_kind == K_XFER);
  assign blk_clr = (st == ST_FLB && d_rsp);
  assign cmd_clr = (st == ST_FLC && d_rsp);

  nwmb_shadow #(.WORD_W(WORD_W)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .blk_ld(blk_ld), .blk_clr(blk_clr), .cmd_ld(cmd_ld), .cmd_clr(cmd_clr),
    .ld_word(m_out),
    .blk_word(sh_blk), .blk_vld(blk_vld), .cmd_word(sh_cmd), .cmd_vld(cmd_vld)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      r_kind  <= K_PLAIN;
      r_addr  <= '0;
      r_data  <= '0;
      r_half  <= 1'b0;
      wr_word <= '0;
      h_err   <= 1'b0;
    end else begin
      h_err <= acc & h_we & misalign;
      unique case (st)
        ST_IDLE: if (take) begin
          r_kind <= in_kind;
          r_addr <= h_addr;
          r_data <= h_wdata;
          r_half <= h_half;
          unique case (in_kind)
            K_BLK:   st <= blk_vld ? ST_IDLE : ST_RD;
            K_CMD:   st <= blk_vld ? ST_FLB : ST_FLC;
            default: st <= ST_RD;
          endcase
        end
        ST_RD: if (d_rsp) begin
          if (r_kind == K_PLAIN) begin
            wr_word <= m_out;
            st      <= ST_WR;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_WR:   if (d_rsp) st <= ST_IDLE;
        ST_FLB:  if (d_rsp) st <= ST_FLC;
        ST_FLC:  if (d_rsp) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign d_req = (st != ST_IDLE);
  assign d_we  = (st == ST_WR) || (st == ST_FLB) || (st == ST_FLC);

  always_comb begin
    unique case (st)
      ST_FLB: begin d_addr = BLK_WORD; d_wdata = sh_blk;  end
      ST_FLC: begin d_addr = CMD_WORD; d_wdata = m_out;   end
      ST_WR:  begin d_addr = r_al;     d_wdata = wr_word; end
      ST_RD:  begin d_addr = r_al;     d_wdata = '0;      end
      default: begin d_addr = '0;      d_wdata = '0;      end
    endcase
  end

  logic unused_ok;
  assign unused_ok = cmd_vld;
endmodule

// File: rtl/nwmb_checker.sv
module nwmb_checker #(
  parameter int          ADDR_W   = 8,
  parameter int unsigned BLK_ADDR = 'h04,
  parameter int unsigned CMD_ADDR = 'h0E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_valid,
  input logic              h_ready,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_half,
  input logic              h_we,
  input logic              h_err,
  input logic              d_req,
  input logic              d_we,
  input logic [ADDR_W-1:0] d_addr,
  input logic              d_rsp,
  input logic              in_flb,
  input logic              blk_vld
);
  localparam logic [ADDR_W-1:0] AL_MASK  = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] BLK_WORD = ADDR_W'(BLK_ADDR) & AL_MASK;
  localparam logic [ADDR_W-1:0] CMD_WORD = ADDR_W'(CMD_ADDR) & AL_MASK;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && !d_rsp |=> d_req && $stable(d_addr) && $stable(d_we)); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> !h_ready); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> $past(h_valid && h_ready && h_we && h_half && h_addr[0])); // R8
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && h_ready && h_we && h_half && h_addr[0] |=> !d_req && h_err); // R8
  AST_FLUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    in_flb && d_rsp |=> d_req && d_we && d_addr == CMD_WORD); // R6
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_flb |-> d_req && d_we && d_addr == BLK_WORD); // R6
  AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && h_ready && h_we && h_half && !h_addr[0] &&
    (h_addr & AL_MASK) == BLK_WORD && blk_vld |=> h_ready && !d_req); // R4
  AST_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && h_ready && !h_we |=> h_ready && !d_req); // R11
endmodule

bind nw_merge_bridge nwmb_checker #(
  .ADDR_W(ADDR_W), .BLK_ADDR(BLK_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
  .h_addr(h_addr), .h_half(h_half), .h_we(h_we), .h_err(h_err),
  .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_rsp(d_rsp),
  .in_flb(st == nwmb_pkg::ST_FLB), .blk_vld(blk_vld)
);

// File: tb/nw_merge_bridge_tb_top.sv
`timescale 1ns/1ps
module nw_merge_bridge_tb_top;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              h_valid = 1'b0, h_half = 1'b0, h_we = 1'b0;
  logic [ADDR_W-1:0] h_addr = '0;
  logic [HALF_W-1:0] h_wdata = '0;
  logic              h_ready, h_err, d_req, d_we;
  logic [ADDR_W-1:0] d_addr;
  logic [WORD_W-1:0] d_wdata;
  logic [WORD_W-1:0] d_rdata = '0;
  logic              d_rsp = 1'b0;

  nw_merge_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_half(h_half), .h_we(h_we),
    .h_err(h_err), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .d_rsp(d_rsp)
  );

  int checks = 0, fails = 0;
  int n_rd = 0;
  logic [31:0] mem [64];
  logic [31:0] mm  [64];
  logic [39:0] exp_q[$];
  string       exp_tag[$];
  logic [31:0] m_blk = '0, m_cmd = '0;
  bit          m_bv = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // downstream stub, compared against the expected write stream on every clock
  int cnt = 0;
  always @(posedge clk) begin
    d_rsp <= 1'b0;
    if (d_req && !d_rsp) begin
      if (cnt == LAT) begin
        cnt   <= 0;
        d_rsp <= 1'b1;
        if (d_we) begin
          mem[d_addr[7:2]] = d_wdata;
          if (exp_q.size() == 0) begin
            chk(0, "R6", "unexpected downstream write", {d_addr, d_wdata}, 40'h0);
          end else begin
            logic [39:0] e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            chk({d_addr, d_wdata} == e, t, "downstream write", {d_addr, d_wdata}, e);
          end
        end else begin
          d_rdata <= mem[d_addr[7:2]];
          n_rd++;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  function automatic logic [31:0] merge(input logic [31:0] b, input logic [15:0] v,
                                        input bit half, input logic [1:0] off);
    logic [31:0] r;
    r = b;
    if (half) begin
      if (off[1]) r[31:16] = v; else r[15:0] = v;
    end else begin
      case (off)
        2'd0: r[7:0]   = v[7:0];
        2'd1: r[15:8]  = v[7:0];
        2'd2: r[23:16] = v[7:0];
        default: r[31:24] = v[7:0];
      endcase
    end
    return r;
  endfunction

  task automatic expect_wr(input logic [7:0] a, input logic [31:0] w, input string tag);
    exp_q.push_back({a, w});
    exp_tag.push_back(tag);
    mm[a[7:2]] = w;
  endtask

  task automatic hw(input logic [7:0] a, input logic [15:0] d, input bit half,
                    input bit we, input string tag);
    int rd0, er;
    bit eerr, quick;
    logic [7:0] al;
    rd0 = n_rd; er = 0; eerr = 0; quick = 0;
    al = a & 8'hFC;
    // reference model
    if (!we) begin
      quick = 1;
    end else if (half && a[0]) begin
      eerr = 1;
    end else if (half && al == 8'h04) begin
      if (m_bv) begin
        m_blk = merge(m_blk, d, 1, a[1:0]);
        quick = 1;
      end else begin
        m_blk = merge(mm[1], d, 1, a[1:0]);
        m_bv = 1; er = 1;
      end
    end else if (half && a == 8'h0C) begin
      m_cmd = merge(mm[3], d, 1, a[1:0]); er = 1;
    end else if (half && a == 8'h0E) begin
      if (m_bv) expect_wr(8'h04, m_blk, tag);
      m_bv = 0;
      expect_wr(8'h0C, merge(m_cmd, d, 1, a[1:0]), tag);
    end else begin
      expect_wr(al, merge(mm[al[7:2]], d, half, a[1:0]), tag); er = 1;
    end
    // drive
    @(negedge clk);
    h_valid = 1'b1; h_addr = a; h_wdata = d; h_half = half; h_we = we;
    while (!h_ready) @(negedge clk);
    @(posedge clk);
    #0.5 h_valid = 1'b0;
    @(negedge clk);
    chk(h_err == eerr, eerr ? "R8" : tag, "error flag", 40'(h_err), 40'(eerr));
    if (quick) chk(h_ready == 1'b1, tag, "ready after one cycle", 40'(h_ready), 40'h1);
    while (!h_ready) @(negedge clk);
    @(negedge clk);
    chk(h_err == 1'b0, "R8", "error flag cleared", 40'(h_err), 40'h0);
    chk(exp_q.size() == 0, tag, "pending expected writes", 40'(exp_q.size()), 40'h0);
    chk(n_rd - rd0 == er, tag, "downstream reads", 40'(n_rd - rd0), 40'(er));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'(i) * 32'h9E3779B1 + 32'h1357_2468;
      mm[i]  = mem[i];
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(h_ready == 1'b1, "R9", "ready in reset", 40'(h_ready), 40'h1);
    chk(d_req == 1'b0, "R9", "no request in reset", 40'(d_req), 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(h_err == 1'b0, "R9", "error low after reset", 40'(h_err), 40'h0);
    chk(h_ready == 1'b1 && d_req == 1'b0, "R9", "idle after reset",
        {38'h0, h_ready, d_req}, 40'h2);

    hw(8'h21, 16'h005A, 0, 1, "R1");
    hw(8'h13, 16'h00C3, 0, 1, "R1");
    hw(8'h22, 16'hBEEF, 1, 1, "R2");
    hw(8'h30, 16'h1234, 1, 1, "R2");
    hw(8'h08, 16'h0000, 1, 0, "R11");
    hw(8'h05, 16'hFFFF, 1, 1, "R8");
    hw(8'h04, 16'h0200, 1, 1, "R3");
    hw(8'h06, 16'h0010, 1, 1, "R4");
    hw(8'h04, 16'h0201, 1, 1, "R4");
    hw(8'h0C, 16'h0013, 1, 1, "R5");
    hw(8'h0E, 16'h1A3B, 1, 1, "R6");
    hw(8'h0E, 16'h0C0D, 1, 1, "R7");
    hw(8'h0C, 16'h0027, 1, 1, "R5");
    hw(8'h0E, 16'h0511, 1, 1, "R7");
    hw(8'h06, 16'h0040, 1, 1, "R3");
    hw(8'h04, 16'h00EE, 0, 1, "R1");
    hw(8'h0F, 16'h0000, 1, 1, "R8");
    hw(8'h0E, 16'h2222, 1, 1, "R6");

    for (int i = 0; i < 16; i++)
      chk(mem[i] == mm[i], "R2", "final word contents", {8'(i), mem[i]}, {8'(i), mm[i]});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule